// File: doc/BRIEF.md
# Transmit Descriptor Address Sequencer

This block decides where a transmit DMA engine reads its next descriptor. It keeps the address of the current descriptor. When the engine has read that descriptor's control word and second address word, it raises a one-cycle request. The block then picks the next descriptor address from one of three sources: the start of the list (ring wrap), the link address in the descriptor (chained list), or the current address stepped forward by the descriptor size plus a gap (contiguous list).

Two control bits in the descriptor's first word choose the source. Bit 21 means end of ring and sends the engine back to the list base. Bit 20 means chained and takes the link address from the second address word. If both bits are set, bit 21 wins. The block also flags when the second buffer size field has to be ignored, which is the case for a chained descriptor. A synchronous reset or a software restart puts the current address back at the list base. All descriptor addresses are word aligned.

Top module: `txdesc_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `curAddr` equals `baseAddr` with bits 1:0 cleared, and `nextValid`, `nextAddr` and `ignoreSize2` are all zero.
- R2: If a request sees bit 21 of `ctrlWord` set, the result is `baseAddr` with bits 1:0 cleared.
- R3: If a request sees bit 21 clear and bit 20 set, the result is `secondAddr` with bits 1:0 cleared.
- R4: If bits 21 and 20 are both set, bit 21 takes precedence and the result is the cleared base address.
- R5: If a request sees both bits clear, the result is `curAddr + 4*(descWords + skipWords)`, taken modulo 2^ADDR_W. No other bit of `ctrlWord` changes the result.
- R6: `nextValid` is high for exactly the one cycle after an accepted request. `nextAddr` holds the result and keeps that value until the next accepted request.
- R7: When `nextValid` goes high, `curAddr` has taken the value of `nextAddr`.
- R8: A `restart` pulse loads `curAddr` from the cleared `baseAddr` on the next cycle. A request in the same cycle as a restart is dropped and gives no `nextValid`.
- R9: `ignoreSize2` is presented together with each result. It equals bit 20 of the `ctrlWord` that produced the result, and it holds until the next result.
- R10: Bits 1:0 of `curAddr` and `nextAddr` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Software restart pulse; reloads the current address from the base |
| nextReq | input | 1 | One-cycle request to compute the next descriptor address |
| baseAddr | input | ADDR_W | List base address |
| ctrlWord | input | CTRL_W | First word of the current descriptor (bit 21 end of ring, bit 20 chained) |
| secondAddr | input | ADDR_W | Second address word of the current descriptor |
| descWords | input | SIZE_W | Descriptor size in 32-bit words |
| skipWords | input | SKIP_W | Gap between descriptors in 32-bit words |
| curAddr | output | ADDR_W | Address of the current descriptor |
| nextAddr | output | ADDR_W | Computed next descriptor address |
| nextValid | output | 1 | One-cycle strobe marking a new `nextAddr` |
| ignoreSize2 | output | 1 | High when the second buffer size field must be ignored |

## Verification
Every result comes from a single register stage. `nextAddr`, `nextValid`, `ignoreSize2` and the updated `curAddr` all appear one clock after the request edge, and a restart shows in `curAddr` one clock after its edge. The bench drives inputs on the falling edge and samples at the following falling edge, which is the first point where those registers hold the result. It then samples again one cycle later to confirm that the strobe has dropped and the address is held. Expected values come from a bench function applied to a model of the current address that the bench keeps itself.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  // Where the next descriptor address comes from
  typedef enum logic [1:0] {
    SRC_STEP = 2'd0,   // current + size + skip
    SRC_BASE = 2'd1,   // ring wrap to list base
    SRC_LINK = 2'd2    // chained: second address word
  } nextSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     loadBase;  // reload current address from base
    logic     advance;   // accept a request this cycle
    logic     linked;    // descriptor is chained (size 2 don't-care)
    nextSrc_e src;       // selected address source
  } seqStrobe_t;

  localparam int END_RING_BIT = 21;
  localparam int CHAIN_BIT    = 20;
  localparam int ALIGN_BITS   = 2;

endpackage

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
#(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              nextReq,
  input  logic [CTRL_W-1:0] ctrlWord,
  output seqStrobe_t        strobe,
  output logic              validQ
);

  localparam logic [CTRL_W-1:0] RING_MASK  = CTRL_W'(1) << END_RING_BIT;
  localparam logic [CTRL_W-1:0] CHAIN_MASK = CTRL_W'(1) << CHAIN_BIT;

  logic endRing;
  logic chained;

  // Masking keeps every bit of the word in the expression
  assign endRing = |(ctrlWord & RING_MASK);
  assign chained = |(ctrlWord & CHAIN_MASK);

  always_comb begin
    strobe          = '0;
    strobe.loadBase = restart;
    strobe.advance  = nextReq & ~restart;
    strobe.linked   = chained;
    // Fixed precedence: end of ring over chaining over stepping
    if (endRing)      strobe.src = SRC_BASE;
    else if (chained) strobe.src = SRC_LINK;
    else              strobe.src = SRC_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= strobe.advance;
  end

endmodule

// File: rtl/txseq_datapath.sv
module txseq_datapath
  import txseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4,
  parameter int SKIP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] secondAddr,
  input  logic [SIZE_W-1:0] descWords,
  input  logic [SKIP_W-1:0] skipWords,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              ignoreSize2
);

  localparam int SUM_W = ((SIZE_W > SKIP_W) ? SIZE_W : SKIP_W) + 1;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);

  logic [SUM_W-1:0]  wordSum;
  logic [ADDR_W-1:0] strideBytes;
  logic [ADDR_W-1:0] baseAligned;
  logic [ADDR_W-1:0] linkAligned;
  logic [ADDR_W-1:0] stepAddr;
  logic [ADDR_W-1:0] candidate;

  assign wordSum     = SUM_W'(descWords) + SUM_W'(skipWords);
  assign strideBytes = ADDR_W'(wordSum) << ALIGN_BITS;
  assign baseAligned = baseAddr & ~LOW_MASK;
  assign linkAligned = secondAddr & ~LOW_MASK;
  assign stepAddr    = (curAddr + strideBytes) & ~LOW_MASK;

  always_comb begin
    unique case (strobe.src)
      SRC_BASE: candidate = baseAligned;
      SRC_LINK: candidate = linkAligned;
      default:  candidate = stepAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.loadBase) begin
      curAddr <= baseAligned;
    end else if (strobe.advance) begin
      curAddr <= candidate;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nextAddr    <= '0;
      ignoreSize2 <= 1'b0;
    end else if (strobe.advance) begin
      nextAddr    <= candidate;
      ignoreSize2 <= strobe.linked;
    end
  end

endmodule

// File: rtl/txdesc_sequencer.sv
module txdesc_sequencer
  import txseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CTRL_W = 32,
  parameter int SIZE_W = 4,
  parameter int SKIP_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              nextReq,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [ADDR_W-1:0] secondAddr,
  input  logic [SIZE_W-1:0] descWords,
  input  logic [SKIP_W-1:0] skipWords,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] nextAddr,
  output logic              nextValid,
  output logic              ignoreSize2
);

  seqStrobe_t strobe;

  txseq_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .nextReq  (nextReq),
    .ctrlWord (ctrlWord),
    .strobe   (strobe),
    .validQ   (nextValid)
  );

  txseq_datapath #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .SKIP_W (SKIP_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .baseAddr    (baseAddr),
    .secondAddr  (secondAddr),
    .descWords   (descWords),
    .skipWords   (skipWords),
    .curAddr     (curAddr),
    .nextAddr    (nextAddr),
    .ignoreSize2 (ignoreSize2)
  );

endmodule

// File: rtl/txseq_chk.sv
module txseq_chk #(
  parameter int ADDR_W = 32,
  parameter int CTRL_W = 32,
  parameter int SIZE_W = 4,
  parameter int SKIP_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              restart,
  input logic              nextReq,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic [ADDR_W-1:0] secondAddr,
  input logic [SIZE_W-1:0] descWords,
  input logic [SKIP_W-1:0] skipWords,
  input logic [ADDR_W-1:0] curAddr,
  input logic [ADDR_W-1:0] nextAddr,
  input logic              nextValid,
  input logic              ignoreSize2
);

  localparam logic [ADDR_W-1:0] LOW2 = ADDR_W'(3);

  logic accept;
  logic ringBit;
  logic chainBit;
  logic [ADDR_W-1:0] stepExp;

  assign accept   = nextReq && !restart;
  assign ringBit  = ctrlWord[21];
  assign chainBit = ctrlWord[20];
  assign stepExp  = curAddr + ((ADDR_W'(descWords) + ADDR_W'(skipWords)) << 2);

  // R10
  align_chk: assert property (@(posedge clk) disable iff (rst)
    (curAddr & LOW2) == '0 && (nextAddr & LOW2) == '0);

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> nextValid);

  // R6
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !nextValid && $stable(nextAddr));

  // R7
  cur_follow_chk: assert property (@(posedge clk) disable iff (rst)
    nextValid |-> curAddr == nextAddr);

  // R8
  restart_load_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> curAddr == ($past(baseAddr) & ~LOW2));

  // R2
  ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    accept && ringBit |=> nextAddr == ($past(baseAddr) & ~LOW2));

  // R3
  chain_link_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !ringBit && chainBit |=> nextAddr == ($past(secondAddr) & ~LOW2));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !ringBit && !chainBit |=> nextAddr == ($past(stepExp) & ~LOW2));

  // R9
  ignore_flag_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> ignoreSize2 == $past(chainBit));

endmodule

bind txdesc_sequencer txseq_chk #(
  .ADDR_W (ADDR_W),
  .CTRL_W (CTRL_W),
  .SIZE_W (SIZE_W),
  .SKIP_W (SKIP_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .restart     (restart),
  .nextReq     (nextReq),
  .baseAddr    (baseAddr),
  .ctrlWord    (ctrlWord),
  .secondAddr  (secondAddr),
  .descWords   (descWords),
  .skipWords   (skipWords),
  .curAddr     (curAddr),
  .nextAddr    (nextAddr),
  .nextValid   (nextValid),
  .ignoreSize2 (ignoreSize2)
);

// File: tb/txdesc_sequencer_bench.sv
`timescale 1ns/1ps
module txdesc_sequencer_bench;

  localparam int ADDR_W = 32;
  localparam int CTRL_W = 32;
  localparam int SIZE_W = 4;
  localparam int SKIP_W = 5;
  localparam logic [31:0] RING  = 32'h0020_0000; // bit 21
  localparam logic [31:0] CHAIN = 32'h0010_0000; // bit 20

  logic clk = 1'b0;
  logic rst, restart, nextReq;
  logic [ADDR_W-1:0] baseAddr, secondAddr;
  logic [CTRL_W-1:0] ctrlWord;
  logic [SIZE_W-1:0] descWords;
  logic [SKIP_W-1:0] skipWords;
  logic [ADDR_W-1:0] curAddr, nextAddr;
  logic nextValid, ignoreSize2;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] expCur;
  logic [31:0] expNext;
  logic        expIgn;

  always #2.5 clk = ~clk;

  txdesc_sequencer #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .SIZE_W(SIZE_W), .SKIP_W(SKIP_W)
  ) u_txdesc_sequencer (
    .clk(clk), .rst(rst), .restart(restart), .nextReq(nextReq),
    .baseAddr(baseAddr), .ctrlWord(ctrlWord), .secondAddr(secondAddr),
    .descWords(descWords), .skipWords(skipWords), .curAddr(curAddr),
    .nextAddr(nextAddr), .nextValid(nextValid), .ignoreSize2(ignoreSize2)
  );

  function automatic logic [31:0] calcNext(logic [31:0] cur, logic [31:0] base,
      logic [31:0] ctl, logic [31:0] sec, logic [3:0] dw, logic [4:0] sk);
    if (ctl[21])      return base & ~32'h3;
    else if (ctl[20]) return sec & ~32'h3;
    else              return (cur + ((32'(dw) + 32'(sk)) << 2)) & ~32'h3;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; leaves at the falling edge one cycle after the result
  task automatic request(logic [31:0] ctl, logic [31:0] sec, logic [3:0] dw,
                         logic [4:0] sk, string tag);
    ctrlWord = ctl; secondAddr = sec; descWords = dw; skipWords = sk;
    nextReq = 1'b1;
    expNext = calcNext(expCur, baseAddr, ctl, sec, dw, sk);
    expIgn  = ctl[20];
    @(negedge clk);
    nextReq = 1'b0;
    chk(nextValid == 1'b1, "R6 valid after request", 32'(nextValid), 32'd1);
    chk(nextAddr == expNext, tag, nextAddr, expNext);
    chk(curAddr == expNext, "R7 current follows result", curAddr, expNext);
    chk(ignoreSize2 == expIgn, "R9 ignore flag", 32'(ignoreSize2), 32'(expIgn));
    chk(nextAddr[1:0] == 2'b00 && curAddr[1:0] == 2'b00, "R10 alignment",
        {nextAddr[1:0], curAddr[1:0]}, 32'd0);
    expCur = expNext;
    @(negedge clk);
    chk(nextValid == 1'b0, "R6 single-cycle strobe", 32'(nextValid), 32'd0);
    chk(nextAddr == expNext, "R6 result held", nextAddr, expNext);
    chk(ignoreSize2 == expIgn, "R9 flag held", 32'(ignoreSize2), 32'(expIgn));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; restart = 1'b0; nextReq = 1'b0;
    baseAddr = 32'h1000_0103; ctrlWord = '0; secondAddr = '0;
    descWords = 4'd4; skipWords = 5'd0;
    repeat (3) @(negedge clk);
    // R1 reset state while in reset
    chk(curAddr == 32'h1000_0100, "R1 reset current", curAddr, 32'h1000_0100);
    chk(nextValid == 1'b0 && nextAddr == '0 && ignoreSize2 == 1'b0,
        "R1 reset outputs", nextAddr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(curAddr == 32'h1000_0100 && nextValid == 1'b0, "R1 after reset",
        curAddr, 32'h1000_0100);
    expCur = 32'h1000_0100;

    // R5 contiguous stepping, other control bits set
    request(32'h8000_0000, 32'hDEAD_BEEF, 4'd4, 5'd0, "R5 step size only");
    request(32'h0001_0000, 32'h0, 4'd4, 5'd3, "R5 step with skip");
    request(32'h0, 32'h0, 4'd0, 5'd0, "R5 zero stride");
    // R3 chained
    request(CHAIN, 32'h2000_0017, 4'd4, 5'd1, "R3 chained link");
    // R2 ring wrap
    request(RING, 32'h3000_0000, 4'd4, 5'd1, "R2 end of ring");
    // R4 both set
    request(RING | CHAIN, 32'h4444_4444, 4'd2, 5'd2, "R4 ring beats chain");
    // R5 wrap modulo 2^32
    request(CHAIN, 32'hFFFF_FFF6, 4'd0, 5'd0, "R3 link near top");
    request(32'h0, 32'h0, 4'd15, 5'd31, "R5 wrap past top");

    // R8 restart alone
    baseAddr = 32'h0000_8002;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    expCur = 32'h0000_8000;
    chk(curAddr == expCur, "R8 restart loads base", curAddr, expCur);
    chk(nextValid == 1'b0, "R8 no strobe on restart", 32'(nextValid), 32'd0);

    // R8 restart and request together: request dropped
    expNext = nextAddr;
    baseAddr = 32'h0000_9000;
    restart = 1'b1; nextReq = 1'b1; ctrlWord = CHAIN; secondAddr = 32'h5555_0000;
    @(negedge clk);
    restart = 1'b0; nextReq = 1'b0;
    expCur = 32'h0000_9000;
    chk(nextValid == 1'b0, "R8 request dropped", 32'(nextValid), 32'd0);
    chk(curAddr == expCur, "R8 restart wins", curAddr, expCur);
    chk(nextAddr == expNext, "R8 result untouched", nextAddr, expNext);

    // Idle cycles: nothing changes
    repeat (3) @(negedge clk);
    chk(nextValid == 1'b0 && curAddr == expCur, "R6 idle quiet", curAddr, expCur);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ctl;
      ctl = $urandom & ~(RING | CHAIN);
      case ($urandom_range(0, 3))
        0: ctl = ctl | RING;
        1: ctl = ctl | CHAIN;
        2: ctl = ctl | RING | CHAIN;
        default: ;
      endcase
      if ($urandom_range(0, 9) == 0) begin
        baseAddr = $urandom;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        expCur = baseAddr & ~32'h3;
        chk(curAddr == expCur, "R8 random restart", curAddr, expCur);
      end
      if ($urandom_range(0, 4) == 0) baseAddr = $urandom;
      request(ctl, $urandom, 4'($urandom), 5'($urandom),
              ctl[21] ? "R2 random ring" : (ctl[20] ? "R3 random chain" : "R5 random step"));
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule